// File: doc/BRIEF.md
# Observation-Only Debug Capture Chain

This block is a serial chain of capture cells whose parallel inputs are wired to arbitrary internal nodes of a design: gate outputs, wires or flop outputs. When the load strobe is high at a rising edge of the system clock, every cell takes a snapshot of the node it watches. When the shift strobe is high, the snapshot moves one cell per clock toward the serial output, so a tester can unload it through a test port and compare it off-chip.

The chain is strictly passive. It has no output other than its serial output and never drives any functional signal. Each cell is modelled as a master/slave pair. The master is the next-state selection (snapshot, serial neighbour or hold) and the slave is the storage register.

Stage 0 takes the serial input. Stage `CHAIN_LEN-1` drives the serial output. Observed bit `k` is captured into stage `k`.

Top module: `obs_scan_chain`

## Requirements
- R1: While the synchronous reset is high at a rising clock edge, every stage is cleared to 0, so `scanOut` reads 0 after that edge.
- R2: When `load` is high at a rising edge, stage k takes `obsVec[k]`, so `scanOut` equals `obsVec[CHAIN_LEN-1]` after that edge.
- R3: When `shift` is high and `load` is low at a rising edge, stage 0 takes `scanIn` and stage k takes the old value of stage k-1.
- R4: When `load` and `shift` are both high at the same edge, the load takes effect and the shift is dropped.
- R5: With `load` and `shift` both low, every stage holds its value.
- R6: After a capture, CHAIN_LEN shift cycles present the captured bits on `scanOut` in the order `obsVec[CHAIN_LEN-1]` down to `obsVec[0]`. The first of these bits is visible before the first shift.
- R7: `obsVec` has no effect on the chain at any edge where `load` is low.
- R8: Reset overrides `load` and `shift` asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| obsVec | input | CHAIN_LEN | Observed internal nodes |
| load | input | 1 | Capture strobe |
| shift | input | 1 | Serial advance strobe |
| scanIn | input | 1 | Serial input into stage 0 |
| scanOut | output | 1 | Serial output from the last stage |

## Verification
Load and shift can both be asserted in one cycle, and reset can coincide with either of them. The bench drives both collisions on purpose. It first loads a known pattern and then raises load and shift together with a different observe vector. A reference model that applies reset first, then load, then shift predicts each following `scanOut` bit, and every bit of the subsequent unload is checked against it. The random phase also draws load and shift independently, so both collide often.

// File: rtl/obs_scan_pkg.sv
package obs_scan_pkg;
  typedef struct packed {
    logic capture;
    logic advance;
  } scanStrobe_t;
endpackage

// File: rtl/obs_scan_ctrl.sv
module obs_scan_ctrl
  import obs_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        shift,
  output scanStrobe_t strobe
);
  always_comb begin
    strobe.capture = load;
    strobe.advance = shift & ~load;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.capture, strobe.advance})); // R4
  AST_SHIFT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (load && shift) |-> !strobe.advance); // R4
endmodule

// File: rtl/obs_scan_path.sv
module obs_scan_path
  import obs_scan_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scanStrobe_t          strobe,
  input  logic [CHAIN_LEN-1:0] obsVec,
  input  logic                 scanIn,
  output logic                 scanOut
);
  localparam int LAST = CHAIN_LEN - 1;
  localparam int PREV = (CHAIN_LEN > 1) ? CHAIN_LEN - 2 : 0;

  logic [CHAIN_LEN-1:0] masterD;
  logic [CHAIN_LEN-1:0] slaveQ;
  logic [CHAIN_LEN-1:0] serialIn;

  for (genvar gi = 0; gi < CHAIN_LEN; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      assign serialIn[gi] = scanIn;
    end else begin : g_body
      assign serialIn[gi] = slaveQ[gi-1];
    end
    assign masterD[gi] = strobe.capture ? obsVec[gi]
                       : strobe.advance ? serialIn[gi]
                       : slaveQ[gi];
  end

  always_ff @(posedge clk) begin
    if (rst) slaveQ <= '0;
    else     slaveQ <= masterD;
  end

  assign scanOut = slaveQ[LAST];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (slaveQ == '0)); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (slaveQ == $past(obsVec))); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> (scanOut == ((CHAIN_LEN > 1) ? $past(slaveQ[PREV]) : $past(scanIn)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobe.capture && !strobe.advance) |=> $stable(slaveQ)); // R5
endmodule

// File: rtl/obs_scan_chain.sv
module obs_scan_chain
  import obs_scan_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CHAIN_LEN-1:0] obsVec,
  input  logic                 load,
  input  logic                 shift,
  input  logic                 scanIn,
  output logic                 scanOut
);
  scanStrobe_t strobe;

  obs_scan_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .shift  (shift),
    .strobe (strobe)
  );

  obs_scan_path #(.CHAIN_LEN(CHAIN_LEN)) i_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .obsVec  (obsVec),
    .scanIn  (scanIn),
    .scanOut (scanOut)
  );
endmodule

// File: tb/test_obs_scan_chain.sv
module test_obs_scan_chain;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] obsVec = '0;
  logic         load = 1'b0;
  logic         shift = 1'b0;
  logic         scanIn = 1'b0;
  logic         scanOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [N-1:0] expQ = '0;

  always #2 clk = ~clk;

  obs_scan_chain #(.CHAIN_LEN(N)) i_obs_scan_chain (
    .clk(clk), .rst(rst), .obsVec(obsVec), .load(load),
    .shift(shift), .scanIn(scanIn), .scanOut(scanOut)
  );

  function automatic logic [N-1:0] nextModel(logic [N-1:0] cur, logic r,
      logic ld, logic sh, logic si, logic [N-1:0] obs);
    if (r)       return '0;
    else if (ld) return obs;
    else if (sh) return {cur[N-2:0], si};
    else         return cur;
  endfunction

  task automatic checkOut(string tag);
    total++;
    if (scanOut !== expQ[N-1]) begin
      bad++;
      $display("FAIL %s: scanOut=%b expected=%b at %0t", tag, scanOut, expQ[N-1], $time);
    end
  endtask

  task automatic step(logic r, logic ld, logic sh, logic si,
      logic [N-1:0] obs, string tag);
    @(negedge clk);
    rst = r; load = ld; shift = sh; scanIn = si; obsVec = obs;
    @(posedge clk);
    expQ = nextModel(expQ, r, ld, sh, si, obs);
    #1;
    checkOut(tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, then unload zeros
    step(1, 0, 0, 0, '0, "R1 reset");
    step(1, 0, 0, 0, '0, "R1 reset");
    for (int i = 0; i < N; i++) step(0, 0, 1, 0, '0, "R1 zeros after reset");
    // R2 and R6: capture then ordered unload
    step(0, 1, 0, 0, 8'hA5, "R2 capture");
    for (int i = 0; i < N; i++) step(0, 0, 1, 1'(i & 1), '0, "R6 ordered unload R3");
    // R4: load and shift together
    step(0, 1, 0, 0, 8'h0F, "R2 capture");
    step(0, 1, 1, 1, 8'hC3, "R4 load beats shift");
    for (int i = 0; i < N; i++) step(0, 0, 1, 0, 8'hFF, "R4 unload after collision");
    // R5 and R7: idle hold with moving observe vector
    step(0, 1, 0, 0, 8'h96, "R2 capture");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 8'(i * 37 + 5), "R5 R7 idle hold");
    for (int i = 0; i < N; i++) step(0, 0, 1, 0, 8'h00, "R7 unload unaffected");
    // R8: reset with load and shift
    step(0, 1, 0, 0, 8'hFF, "R2 capture");
    step(1, 1, 1, 1, 8'hFF, "R8 reset overrides");
    for (int i = 0; i < N; i++) step(0, 0, 1, 0, '0, "R8 cleared chain");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic r, ld, sh, si;
      logic [N-1:0] ob;
      r  = ($urandom % 50) == 0;
      ld = ($urandom % 6) == 0;
      sh = ($urandom % 3) != 0;
      si = 1'($urandom);
      ob = N'($urandom);
      step(r, ld, sh, si, ob, "R3 random mix R4 R5");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule